// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit translates a 32-bit effective address by checking it against a small set of block mapping entries. Each entry is a pair of 32-bit words. The upper word carries the block's effective base, a block-length code and two valid bits. The lower word carries the physical base and a 2-bit protection code. There are two separate sets of entries: one for instruction fetches and one for loads and stores. The kind of access picks which set is searched.

Entries are loaded through a plain one-word write port. A lookup is offered on a valid/ready request channel. Its result appears on a valid/ready response channel one cycle after the request is accepted. The result holds:
- a hit flag,
- the translated, page-aligned physical address,
- the read/write/execute permissions of the matching entry,
- a verdict on whether the requested access is allowed.

Back-pressure works as follows. A request is accepted only when the response register is empty, or when it is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and `req_ready` stays low.

Top module: `bat_matcher`

## Requirements
- R1: After reset `rsp_valid` is low and `req_ready` is high. Every entry of both sets reads as zero, so it is invalid, and any lookup misses.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored into one entry word. `wr_isel`=1 selects the fetch set and 0 the data set. `wr_idx` selects the entry. `wr_hi`=1 selects the upper word and 0 the lower word. The new value is used by lookups accepted in later cycles.
- R3: Upper-word bit 1 enables the entry in privileged mode (`req_priv`=1). Upper-word bit 0 enables it in user mode (`req_priv`=0). An entry that is not enabled for the current mode never hits.
- R4: An enabled entry builds a mask in two steps. Start from 0xFFFE0000. Then clear every bit that is set in (upper AND 0x1FFC) shifted left by 15, so the length code sits in bits 12:2. The entry hits when (address AND mask) equals (upper AND 0xFFFE0000).
- R5: On a hit the address output is ((lower AND mask) OR (address AND NOT mask)) with bits 11:0 cleared.
- R6: When several entries hit, the lowest-numbered one supplies the address and permissions.
- R7: Lower-word bits 1:0 are the protection code. `rsp_perm` bit 0 is read, bit 1 is write and bit 2 is execute. Code 0 gives 3'b000. Code 2 gives 3'b111. Codes 1 and 3 give 3'b101.
- R8: `req_kind` 2 is a fetch and searches the fetch set. `req_kind` 0 is a load and 1 is a store, and both search the data set. Kind 3 behaves as a load.
- R9: `rsp_allow` is high only on a hit, and then only with execute permission for a fetch, write permission for a store, or read permission for a load.
- R10: On a miss `rsp_hit`, `rsp_paddr`, `rsp_perm` and `rsp_allow` are all zero.
- R11: A request accepted at a clock edge gives `rsp_valid` high after that edge. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While the response is stalled, its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_isel | input | 1 | 1 = fetch set, 0 = data set |
| wr_idx | input | IDX_W | Entry index to write |
| wr_hi | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_addr | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_priv | input | 1 | 1 = privileged mode |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_hit | output | 1 | An entry matched |
| rsp_paddr | output | 32 | Translated page address |
| rsp_perm | output | 3 | {exec, write, read} |
| rsp_allow | output | 1 | Access permitted |

## Verification
The assertions check the following on every cycle:
- the response handshake: the one-cycle latency, the stall hold and that no request is taken during a stall;
- that a miss outputs all zeros;
- that addresses are page-aligned;
- that the permission field only ever holds one of its three legal codes;
- that the verdict matches the permission bit of the access kind that was accepted.

Only the bench scenarios can show whether the right entry was chosen and whether the address arithmetic is correct. These include the valid-bit gating by mode, the block-length masks at block boundaries, the lowest-index priority between overlapping entries, the separation between the fetch and data sets, and the effect of rewriting an entry.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int EPI_LSB   = 17;
  localparam int LEN_LSB   = 2;
  localparam int LEN_W     = 11;
  localparam int USR_BIT   = 0;
  localparam int SUP_BIT   = 1;
  localparam logic [ADDR_W-1:0] EPI_FIELD = {{(ADDR_W-EPI_LSB){1'b1}}, {EPI_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] PAGE_KEEP = {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic perm_t prot_decode(input logic [1:0] code);
    perm_t p;
    unique case (code)
      2'd0:    p = '{x: 1'b0, w: 1'b0, r: 1'b0};
      2'd2:    p = '{x: 1'b1, w: 1'b1, r: 1'b1};
      default: p = '{x: 1'b1, w: 1'b0, r: 1'b1};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bat_entry_bank.sv
module bat_entry_bank
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_hi,
  input  logic [ADDR_W-1:0]              wr_data,
  output logic [NUM_ENT-1:0][ADDR_W-1:0] upper_q,
  output logic [NUM_ENT-1:0][ADDR_W-1:0] lower_q
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        upper_q[g] <= '0;
        lower_q[g] <= '0;
      end else if (sel) begin
        if (wr_hi) upper_q[g] <= wr_data;
        else       lower_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
  import bat_pkg::*;
(
  input  logic [ADDR_W-1:0] upper,
  input  logic [ADDR_W-1:0] lower,
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  output logic              hit,
  output logic [ADDR_W-1:0] paddr,
  output perm_t             perm
);
  logic              enabled;
  logic [ADDR_W-1:0] len_bits;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] base;

  always_comb begin
    enabled  = priv ? upper[SUP_BIT] : upper[USR_BIT];
    len_bits = ADDR_W'(upper[LEN_LSB +: LEN_W]) << EPI_LSB;
    mask     = enabled ? (EPI_FIELD & ~len_bits) : '0;
    base     = upper & EPI_FIELD;
    hit      = (mask != '0) && ((addr & mask) == base);
    paddr    = ((lower & mask) | (addr & ~mask)) & PAGE_KEEP;
    perm     = prot_decode(lower[1:0]);
  end
endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic [NUM_ENT-1:0]             hit_vec,
  input  logic [NUM_ENT-1:0][ADDR_W-1:0] paddr_vec,
  input  perm_t [NUM_ENT-1:0]            perm_vec,
  output logic                           any_hit,
  output logic [ADDR_W-1:0]              paddr,
  output perm_t                          perm
);
  always_comb begin
    any_hit = 1'b0;
    paddr   = '0;
    perm    = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        paddr   = paddr_vec[i];
        perm    = perm_vec[i];
      end
    end
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int  NUM_ENT = 4,
  localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_isel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic [1:0]       req_kind,
  input  logic             req_priv,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [31:0]      rsp_paddr,
  output logic [2:0]       rsp_perm,
  output logic             rsp_allow
);
  logic [NUM_ENT-1:0][ADDR_W-1:0] i_upper, i_lower, d_upper, d_lower;
  logic [NUM_ENT-1:0][ADDR_W-1:0] s_upper, s_lower;
  logic [NUM_ENT-1:0]             hit_vec;
  logic [NUM_ENT-1:0][ADDR_W-1:0] paddr_vec;
  perm_t [NUM_ENT-1:0]            perm_vec;
  logic                           any_hit;
  logic [ADDR_W-1:0]              pick_paddr;
  perm_t                          pick_perm;
  logic                           verdict;
  logic                           is_fetch;

  bat_entry_bank #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_ibank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_isel), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_data(wr_data), .upper_q(i_upper), .lower_q(i_lower)
  );

  bat_entry_bank #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_dbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !wr_isel), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_data(wr_data), .upper_q(d_upper), .lower_q(d_lower)
  );

  assign is_fetch = (acc_kind_e'(req_kind) == ACC_FETCH);
  assign s_upper  = is_fetch ? i_upper : d_upper;
  assign s_lower  = is_fetch ? i_lower : d_lower;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_eval
    bat_entry_eval u_eval (
      .upper(s_upper[g]), .lower(s_lower[g]), .addr(req_addr), .priv(req_priv),
      .hit(hit_vec[g]), .paddr(paddr_vec[g]), .perm(perm_vec[g])
    );
  end

  bat_prio_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .hit_vec(hit_vec), .paddr_vec(paddr_vec), .perm_vec(perm_vec),
    .any_hit(any_hit), .paddr(pick_paddr), .perm(pick_perm)
  );

  always_comb begin
    unique case (acc_kind_e'(req_kind))
      ACC_FETCH: verdict = pick_perm.x;
      ACC_STORE: verdict = pick_perm.w;
      default:   verdict = pick_perm.r;
    endcase
    verdict = verdict && any_hit;
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_allow <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= any_hit;
        rsp_paddr <= any_hit ? pick_paddr : '0;
        rsp_perm  <= any_hit ? pick_perm : '0;
        rsp_allow <= verdict;
      end
    end
  end
endmodule

// File: rtl/bat_matcher_chk.sv
module bat_matcher_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_kind,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic [31:0] rsp_paddr,
  input logic [2:0]  rsp_perm,
  input logic        rsp_allow
);
  logic [1:0] kind_q;
  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= 2'd0;
    else if (req_valid && req_ready) kind_q <= req_kind;
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)
      && $stable(rsp_perm) && $stable(rsp_allow)); // R11
  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R11
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_paddr == 32'd0 && rsp_perm == 3'd0 && !rsp_allow); // R10
  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_paddr[11:0] == 12'd0); // R5
  AST_PERM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_perm == 3'b000 || rsp_perm == 3'b101 || rsp_perm == 3'b111); // R7
  AST_VERDICT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_allow == (rsp_hit && ((kind_q == 2'd2) ? rsp_perm[2] :
                                (kind_q == 2'd1) ? rsp_perm[1] : rsp_perm[0]))); // R9
endmodule

bind bat_matcher bat_matcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_allow(rsp_allow)
);

// File: tb/bat_matcher_bench.sv
module bat_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_isel = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0, req_priv = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_allow;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] iu [4], il [4], du [4], dl [4];

  always #4 clk = ~clk;

  bat_matcher u_bat_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_isel(wr_isel), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_allow(rsp_allow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit isel, input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_isel = isel; wr_idx = 2'(idx); wr_hi = hi; wr_data = d;
    if (isel) begin if (hi) iu[idx] = d; else il[idx] = d; end
    else begin if (hi) du[idx] = d; else dl[idx] = d; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ent(input bit isel, input int idx, input logic [31:0] u, input logic [31:0] l);
    wr(isel, idx, 1'b1, u);
    wr(isel, idx, 1'b0, l);
  endtask

  // reference computed from the requirement text
  function automatic logic [37:0] model(input logic [31:0] a, input int kind, input bit priv);
    logic [31:0] u, l, m, pa;
    logic [2:0] pm;
    bit h, al, en;
    h = 0; pa = 0; pm = 0;
    for (int i = 0; i < 4; i++) begin
      u = (kind == 2) ? iu[i] : du[i];
      l = (kind == 2) ? il[i] : dl[i];
      en = priv ? u[1] : u[0];
      m = en ? (32'hFFFE0000 & ~((u & 32'h1FFC) << 15)) : 32'h0;
      if (!h && m != 0 && (a & m) == (u & 32'hFFFE0000)) begin
        h = 1;
        pa = ((l & m) | (a & ~m)) & 32'hFFFFF000;
        pm = (l[1:0] == 2'd0) ? 3'b000 : (l[1:0] == 2'd2) ? 3'b111 : 3'b101;
      end
    end
    al = h && ((kind == 2) ? pm[2] : (kind == 1) ? pm[1] : pm[0]);
    return {1'b1, h, pa, pm, al};
  endfunction

  task automatic look(input logic [31:0] a, input int kind, input bit priv, input string tag);
    logic [37:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = 2'(kind); req_priv = priv;
    exp = model(a, kind, priv);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, 64'({rsp_valid, rsp_hit, rsp_paddr, rsp_perm, rsp_allow}), 64'(exp));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin iu[i] = 0; il[i] = 0; du[i] = 0; dl[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    look(32'h1000_0000, 0, 1, "R1 empty miss");
    look(32'h1000_0000, 2, 0, "R1 empty miss fetch");

    // data set: D0 sup-only 128K, D1 256M both, D2 overlaps D1, D3 overlaps D0
    set_ent(0, 0, 32'h1000_0002, 32'h8000_0002);
    set_ent(0, 1, 32'h2000_1FFF, 32'h9000_0001);
    set_ent(0, 2, 32'h2000_0003, 32'h7000_0000);
    set_ent(0, 3, 32'h1000_0003, 32'hA000_0003);
    // fetch set: I0 2M both RX, I1 user-only no access
    set_ent(1, 0, 32'h1000_003F, 32'hC000_0001);
    set_ent(1, 1, 32'h3000_0001, 32'hB000_0000);

    // R3 R4 R5 R6 R7 R8 R9 R10: address/kind/mode sweep
    for (int n = 0; n < 16; n++) begin
      for (int o = 0; o < 6; o++) begin
        logic [31:0] off;
        off = (o == 0) ? 32'h0 : (o == 1) ? 32'h1_F123 : (o == 2) ? 32'h2_0000 :
              (o == 3) ? 32'h1F_FFFF : (o == 4) ? 32'h20_0000 : 32'h0FFF_FFFF;
        for (int k = 0; k < 3; k++)
          for (int p = 0; p < 2; p++)
            look({4'(n), 28'h0} | off, k, p[0], "R3 R4 R5 R6 R7 R8 R9 R10 sweep");
      end
    end

    // R6: D1 (index 1) beats D2 at same address, store allowed? D1 code 1 -> no write
    look(32'h2000_5000, 1, 0, "R6 lowest index wins");
    check("R6 paddr", 64'(rsp_paddr), 64'h9000_5000);
    // R3: user mode skips D0, hits D3
    look(32'h1000_4000, 0, 0, "R3 user skips sup-only");
    check("R3 paddr", 64'(rsp_paddr), 64'hA000_4000);
    // R10: miss zeros
    look(32'h5000_0000, 0, 1, "R10 miss");
    check("R10 paddr zero", 64'(rsp_paddr), 64'd0);

    // R4 R5: block-length sweep on a fresh entry at 0x4000_0000
    for (int b = 0; b <= 11; b++) begin
      logic [31:0] len, sz;
      len = (32'h1 << b) - 1;
      sz  = 32'h2_0000 << b;
      set_ent(0, 0, 32'h4000_0000 | (len << 2) | 32'h3, 32'h6000_0002);
      look(32'h4000_0000 + sz - 32'h1000, 1, 1, "R4 R5 last page in block");
      look(32'h4000_0000 + sz - 32'h1, 0, 0, "R5 in-block offset");
      look(32'h4000_0000 + sz, 1, 1, "R4 first page past block");
    end

    // R2: rewrite lower word, new physical base visible
    wr(0, 0, 1'b0, 32'hE000_0001);
    look(32'h4000_3000, 0, 1, "R2 rewrite");
    check("R2 paddr", 64'(rsp_paddr), 64'hE000_3000);
    // R8: fetch at data-only address misses
    look(32'h4000_3000, 2, 1, "R8 fetch ignores data set");
    check("R8 hit", 64'(rsp_hit), 64'd0);

    // R11: stall holds response and blocks new requests
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h1000_2000; req_kind = 2'd2; req_priv = 1'b1;
    @(negedge clk);
    req_addr = 32'h5000_0000; req_kind = 2'd0;
    check("R11 valid after accept", 64'(rsp_valid), 64'd1);
    check("R11 ready low in stall", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    check("R11 held", 64'({rsp_hit, rsp_paddr, rsp_perm, rsp_allow}), 64'({1'b1, 32'hC000_2000, 3'b101, 1'b1}));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next response", 64'({rsp_valid, rsp_hit, rsp_paddr}), 64'({1'b1, 1'b0, 32'h0}));
    @(negedge clk);
    check("R11 drained", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule